// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects up to 77 interrupt inputs and presents one interrupt request line to a processor. Each source has its own sensing type, a 3-bit priority and a programmable vector. The controller picks the most urgent enabled pending source and raises the request only when that source outranks the interrupt currently being serviced. Software reaches the block through a simple synchronous register bus. Write data is taken on the clock edge where the write strobe is high, and read data appears on the clock edge after a read strobe.

Per-source settings are reached indirectly. Software first writes a source index to the select register. The mode, vector, enable, disable and clear registers then act on that source. A read of the acknowledge register returns the winning source's vector and pushes its priority onto a nesting stack of up to eight levels. If no source is eligible, the read returns the spurious vector instead. A write to the end-of-interrupt register pops one level from the stack. Falling-edge and active-low sensing are allowed only on sources that the `EXT_MASK` parameter marks as external.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq` is low and every source is disabled and not pending. The stack is empty. The select (offset 0), mode (offset 1), vector (offset 2) and spurious (offset 8) registers all read zero.
- R2: A write to select (offset 0) whose value is 77 or more is ignored, and select keeps its previous index.
- R3: The mode register (offset 1) holds the priority in bits 2:0 and the sensing type in bits 5:4: 0 = high level, 1 = low level, 2 = rising edge, 3 = falling edge. A mode write with type 1 or 3 to a source not marked external leaves that source's mode unchanged.
- R4: A write with bit 0 set to offset 3 enables the selected source. A write with bit 0 set to offset 4 masks it. A masked source neither raises `irq` nor wins an acknowledge.
- R5: An edge-sensed source latches its pending flag on the selected edge. The flag is cleared by an acknowledge of that source, or by a write with bit 0 set to offset 5 while the source is selected.
- R6: A level-sensed source is pending exactly while its input sits at the active level. An acknowledge does not clear it.
- R7: `irq` is high when some enabled pending source has a priority strictly above the top of the stack, or when the stack is empty and any enabled source is pending. Otherwise it is low.
- R8: A read of offset 6 returns the vector of the enabled pending source with the highest priority, breaking ties by the lowest index. The read pushes that source's priority onto the stack.
- R9: A read of offset 6 when no source qualifies under R7 returns the spurious register value and leaves the stack unchanged.
- R10: A write to offset 7 pops one stack level, and has no effect on an empty stack. Eight such writes empty the stack from any state.
- R11: A write to offset 9 takes effect only when bits 31:8 equal the key `WP_KEY`. Its bit 0 then sets or clears write protection. While protection is set, writes to mode, vector and spurious are ignored.
- R12: An edge that arrives while a source is masked is still latched. It raises `irq` once the source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Interrupt source inputs, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach is a stack three levels deep with a lower-priority source already latched beneath it. In that state `irq` must stay low through two end-of-interrupt writes and rise only on the third. The bench builds this by pulsing sources of priority 2, 5 and 7 in turn and acknowledging each one. It then pulses the priority-2 source again and pops one level at a time, checking `irq` after each pop. Equal-priority tie-breaking is driven with a level source and an edge source of the same priority that become pending together.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SENSE_HIGH = 2'd0,
    SENSE_LOW  = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_FALL = 2'd3
  } sense_e;

  localparam logic [3:0] OFS_SEL   = 4'd0;
  localparam logic [3:0] OFS_MODE  = 4'd1;
  localparam logic [3:0] OFS_VEC   = 4'd2;
  localparam logic [3:0] OFS_ENA   = 4'd3;
  localparam logic [3:0] OFS_DIS   = 4'd4;
  localparam logic [3:0] OFS_CLR   = 4'd5;
  localparam logic [3:0] OFS_ACK   = 4'd6;
  localparam logic [3:0] OFS_EOI   = 4'd7;
  localparam logic [3:0] OFS_SPUR  = 4'd8;
  localparam logic [3:0] OFS_WPROT = 4'd9;
endpackage

// File: rtl/pic_src_bank.sv
module pic_src_bank
  import pic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 77,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned VEC_W   = 32,
  parameter int unsigned SEL_W   = 7,
  parameter logic [NUM_SRC-1:0] EXT_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [SEL_W-1:0]  sel,
  input  logic              mode_we,
  input  sense_e            mode_sense,
  input  logic [PRIO_W-1:0] mode_prio,
  input  logic              vec_we,
  input  logic [VEC_W-1:0]  vec_wdata,
  input  logic              ena_we,
  input  logic              dis_we,
  input  logic              clr_we,
  input  logic              ack_clr,
  input  logic [SEL_W-1:0]  ack_idx,
  output logic [NUM_SRC-1:0] req,
  output logic [PRIO_W-1:0] prio [NUM_SRC],
  output sense_e            sense [NUM_SRC],
  output logic [VEC_W-1:0]  vec [NUM_SRC]
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hit, mode_ok, prev_q, en_q, edge_q, edge_hit, level_act;

    assign hit       = (sel == SEL_W'(i));
    // Inverted-polarity types (low level, falling edge) only on external sources
    assign mode_ok   = EXT_MASK[i] || !mode_sense[0];
    assign edge_hit  = sense[i][0] ? (prev_q && !src_in[i]) : (!prev_q && src_in[i]);
    assign level_act = src_in[i] ^ sense[i][0];
    assign req[i]    = en_q && (sense[i][1] ? edge_q : level_act);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q   <= 1'b0;
        en_q     <= 1'b0;
        edge_q   <= 1'b0;
        sense[i] <= SENSE_HIGH;
        prio[i]  <= '0;
        vec[i]   <= '0;
      end else begin
        prev_q <= src_in[i];
        if (hit && ena_we) en_q <= 1'b1;
        else if (hit && dis_we) en_q <= 1'b0;
        // A fresh edge wins over any clear in the same cycle
        if (sense[i][1] && edge_hit) edge_q <= 1'b1;
        else if ((hit && (clr_we || (mode_we && mode_ok))) || (ack_clr && ack_idx == SEL_W'(i)))
          edge_q <= 1'b0;
        if (hit && mode_we && mode_ok) begin
          sense[i] <= mode_sense;
          prio[i]  <= mode_prio;
        end
        if (hit && vec_we) vec[i] <= vec_wdata;
      end
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int unsigned NUM_SRC = 77,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned IDX_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic [PRIO_W-1:0] prio [NUM_SRC],
  output logic              win_valid,
  output logic [IDX_W-1:0]  win_idx,
  output logic [PRIO_W-1:0] win_prio
);
  logic              found;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio;

  // Descending scan with >= leaves the lowest index among the top priority
  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_prio = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i] && (!found || prio[i] >= best_prio)) begin
        found     = 1'b1;
        best_idx  = IDX_W'(i);
        best_prio = prio[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_idx   <= '0;
      win_prio  <= '0;
    end else begin
      win_valid <= found;
      win_idx   <= best_idx;
      win_prio  <= best_prio;
    end
  end
endmodule

// File: rtl/pic_nest_stack.sv
module pic_nest_stack #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [CNT_W-1:0]  depth,
  output logic              empty,
  output logic [PRIO_W-1:0] top
);
  logic [PRIO_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, top_ptr;

  assign wr_ptr  = PTR_W'(depth);
  assign top_ptr = PTR_W'(depth - CNT_W'(1));
  assign empty   = (depth == '0);
  assign top     = empty ? '0 : mem[top_ptr];

  // Entries carry no reset so they map onto distributed RAM
  always_ff @(posedge clk) begin
    if (push && depth != CNT_W'(DEPTH)) mem[wr_ptr] <= push_prio;
  end

  always_ff @(posedge clk) begin
    if (rst) depth <= '0;
    else if (push && depth != CNT_W'(DEPTH)) depth <= depth + CNT_W'(1);
    else if (pop && !empty) depth <= depth - CNT_W'(1);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 77,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned VEC_W   = 32,
  parameter logic [NUM_SRC-1:0] EXT_MASK = {{5{1'b1}}, {(NUM_SRC-5){1'b0}}},
  parameter logic [23:0] WP_KEY  = 24'h575041
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [3:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq
);
  localparam int unsigned SEL_W      = $clog2(NUM_SRC);
  localparam int unsigned NEST_DEPTH = 2 ** PRIO_W;
  localparam int unsigned CNT_W      = $clog2(NEST_DEPTH + 1);

  logic [SEL_W-1:0]  sel_q;
  logic [VEC_W-1:0]  spur_q;
  logic              wp_q;
  logic [NUM_SRC-1:0] req;
  logic [PRIO_W-1:0] prio [NUM_SRC];
  sense_e            sense [NUM_SRC];
  logic [VEC_W-1:0]  vec [NUM_SRC];
  logic              win_valid, stk_empty, ack_rd, ack_ok, eoi_we, eligible;
  logic [SEL_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio, stk_top;
  logic [CNT_W-1:0]  stk_depth;

  function automatic logic wr_at(input logic [3:0] ofs);
    return bus_wr && (bus_addr == ofs);
  endfunction

  assign eligible = win_valid && (stk_empty || win_prio > stk_top);
  assign ack_rd   = bus_rd && (bus_addr == OFS_ACK);
  assign ack_ok   = ack_rd && eligible;
  assign eoi_we   = wr_at(OFS_EOI);

  pic_src_bank #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .SEL_W(SEL_W), .EXT_MASK(EXT_MASK)
  ) bank_i (
    .clk(clk), .rst(rst), .src_in(src_in), .sel(sel_q),
    .mode_we(wr_at(OFS_MODE) && !wp_q),
    .mode_sense(sense_e'(bus_wdata[5:4])),
    .mode_prio(bus_wdata[PRIO_W-1:0]),
    .vec_we(wr_at(OFS_VEC) && !wp_q),
    .vec_wdata(bus_wdata[VEC_W-1:0]),
    .ena_we(wr_at(OFS_ENA) && bus_wdata[0]),
    .dis_we(wr_at(OFS_DIS) && bus_wdata[0]),
    .clr_we(wr_at(OFS_CLR) && bus_wdata[0]),
    .ack_clr(ack_ok), .ack_idx(win_idx),
    .req(req), .prio(prio), .sense(sense), .vec(vec)
  );

  pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(SEL_W)) arb_i (
    .clk(clk), .rst(rst), .req(req), .prio(prio),
    .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
  );

  pic_nest_stack #(.DEPTH(NEST_DEPTH), .PRIO_W(PRIO_W)) stk_i (
    .clk(clk), .rst(rst), .push(ack_ok), .push_prio(win_prio), .pop(eoi_we),
    .depth(stk_depth), .empty(stk_empty), .top(stk_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      spur_q    <= '0;
      wp_q      <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq <= eligible;
      if (wr_at(OFS_SEL) && bus_wdata < NUM_SRC) sel_q <= bus_wdata[SEL_W-1:0];
      if (wr_at(OFS_SPUR) && !wp_q) spur_q <= bus_wdata[VEC_W-1:0];
      if (wr_at(OFS_WPROT) && bus_wdata[31:8] == WP_KEY) wp_q <= bus_wdata[0];
      if (bus_rd) begin
        case (bus_addr)
          OFS_SEL:   bus_rdata <= 32'(sel_q);
          OFS_MODE:  bus_rdata <= 32'({sense[sel_q], 4'(prio[sel_q])});
          OFS_VEC:   bus_rdata <= 32'(vec[sel_q]);
          OFS_ACK:   bus_rdata <= eligible ? 32'(vec[win_idx]) : 32'(spur_q);
          OFS_SPUR:  bus_rdata <= 32'(spur_q);
          OFS_WPROT: bus_rdata <= {31'b0, wp_q};
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int unsigned NUM_SRC = 77,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned VEC_W   = 32,
  parameter int unsigned SEL_W   = 7,
  parameter int unsigned CNT_W   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             bus_wr,
  input logic [3:0]       bus_addr,
  input logic [CNT_W-1:0] depth,
  input logic [SEL_W-1:0] sel,
  input logic [VEC_W-1:0] spur,
  input logic             wp,
  input logic             ack_ok,
  input logic             pop
);
  assert_sel_range_R2: assert property (@(posedge clk) disable iff (rst)
    sel < SEL_W'(NUM_SRC));

  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(DEPTH));

  assert_ack_push_R8: assert property (@(posedge clk) disable iff (rst)
    ack_ok |=> depth == $past(depth) + CNT_W'(1));

  assert_eoi_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (pop && !ack_ok && depth != '0) |=> depth == $past(depth) - CNT_W'(1));

  assert_eoi_empty_R10: assert property (@(posedge clk) disable iff (rst)
    (pop && !ack_ok && depth == '0) |=> depth == '0);

  assert_full_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (depth == CNT_W'(DEPTH)) |=> !irq);

  assert_wp_spur_R11: assert property (@(posedge clk) disable iff (rst)
    (wp && bus_wr && bus_addr == 4'd8) |=> $stable(spur));
endmodule

bind prio_irq_ctrl pic_chk #(
  .NUM_SRC(NUM_SRC), .DEPTH(NEST_DEPTH), .VEC_W(VEC_W), .SEL_W(SEL_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .irq(irq), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .depth(stk_depth), .sel(sel_q), .spur(spur_q), .wp(wp_q),
  .ack_ok(ack_ok), .pop(eoi_we)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int NSRC = 77;
  localparam logic [23:0] KEY = 24'h575041;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] src = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic rd_d = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .src_in(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) rd_d <= bus_rd;

  // Monitor: one result per read strobe, compared in issue order
  always @(negedge clk) begin
    if (rd_d && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    sb_q.push_back('{e, tag});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    idle(4);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
    end
  endtask

  task automatic pulse(input int i);
    @(negedge clk); src[i] = 1'b1;
    @(negedge clk); src[i] = 1'b0;
  endtask

  task automatic setup_src(input int i, input logic [31:0] mode, input logic [31:0] v, input bit en);
    wr(4'd0, i); wr(4'd1, mode); wr(4'd2, v);
    if (en) wr(4'd3, 1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(4'd0, 0, "R1 select"); rd(4'd1, 0, "R1 mode"); rd(4'd2, 0, "R1 vector");
    rd(4'd8, 0, "R1 spurious");
    rd(4'd6, 0, "R9 ack at reset returns spurious");
    // R2 select range
    wr(4'd0, 77); rd(4'd0, 0, "R2 index 77 ignored");
    wr(4'd0, 76); rd(4'd0, 76, "R2 index 76 taken");
    wr(4'd0, 200); rd(4'd0, 76, "R2 index 200 ignored");
    // configuration
    wr(4'd8, 32'hDEAD);
    setup_src(3, 32'h22, 32'h103, 1);
    setup_src(10, 32'h05, 32'h10A, 1);
    setup_src(20, 32'h25, 32'h114, 1);
    setup_src(40, 32'h27, 32'h128, 0);
    setup_src(74, 32'h34, 32'h14A, 1);
    rd(4'd1, 32'h34, "R3 falling accepted on external");
    wr(4'd0, 3); wr(4'd1, 32'h31); rd(4'd1, 32'h22, "R3 falling refused on internal");
    wr(4'd1, 32'h12); rd(4'd1, 32'h22, "R3 low level refused on internal");
    chk_irq(1'b0, "R7 nothing pending");
    // R5 edge latch and ack clear
    pulse(3);
    chk_irq(1'b1, "R5 rising edge latched");
    rd(4'd6, 32'h103, "R8 single source ack");
    chk_irq(1'b0, "R7 in service");
    wr(4'd7, 0);
    chk_irq(1'b0, "R5 ack cleared edge");
    // R8 tie, R6 level
    @(negedge clk); src[10] = 1'b1;
    pulse(20); pulse(3);
    chk_irq(1'b1, "R7 multiple pending");
    rd(4'd6, 32'h10A, "R8 tie goes to lower index");
    chk_irq(1'b0, "R7 equal priority blocked");
    wr(4'd7, 0);
    chk_irq(1'b1, "R6 level still pending");
    rd(4'd6, 32'h10A, "R6 level not cleared by ack");
    @(negedge clk); src[10] = 1'b0;
    wr(4'd7, 0); idle(4);
    rd(4'd6, 32'h114, "R8 edge source next");
    rd(4'd6, 32'hDEAD, "R9 lower priority gives spurious");
    wr(4'd7, 0); wr(4'd7, 0);
    chk_irq(1'b1, "R10 stack emptied");
    rd(4'd6, 32'h103, "R8 lowest priority last");
    wr(4'd7, 0);
    chk_irq(1'b0, "R7 all serviced");
    // R12 latched while masked
    pulse(40);
    chk_irq(1'b0, "R12 masked source quiet");
    wr(4'd0, 40); wr(4'd3, 1);
    chk_irq(1'b1, "R12 latched edge after enable");
    rd(4'd6, 32'h128, "R12 ack masked-latched source");
    wr(4'd7, 0);
    // R4 disable, R5 clear
    wr(4'd0, 3); wr(4'd4, 1);
    pulse(3);
    chk_irq(1'b0, "R4 disabled source quiet");
    wr(4'd5, 1); wr(4'd3, 1);
    chk_irq(1'b0, "R5 clear removed pending");
    // falling edge and low level on external sources
    @(negedge clk); src[74] = 1'b1;
    chk_irq(1'b0, "R3 rising ignored on falling source");
    @(negedge clk); src[74] = 1'b0;
    chk_irq(1'b1, "R3 falling edge latched");
    rd(4'd6, 32'h14A, "R3 falling source ack");
    wr(4'd7, 0);
    @(negedge clk); src[73] = 1'b1;
    setup_src(73, 32'h16, 32'h149, 1);
    chk_irq(1'b0, "R6 low level inactive when high");
    @(negedge clk); src[73] = 1'b0;
    chk_irq(1'b1, "R6 low level active");
    rd(4'd6, 32'h149, "R6 low level ack");
    wr(4'd7, 0);
    @(negedge clk); src[73] = 1'b1;
    chk_irq(1'b0, "R6 low level released");
    // R10 nesting three deep
    pulse(3); idle(4);
    rd(4'd6, 32'h103, "R10 level 2 in");
    pulse(20); idle(4);
    rd(4'd6, 32'h114, "R10 level 5 in");
    pulse(40); idle(4);
    rd(4'd6, 32'h128, "R10 level 7 in");
    pulse(3);
    chk_irq(1'b0, "R10 prio 2 below top 7");
    wr(4'd7, 0);
    chk_irq(1'b0, "R10 prio 2 below top 5");
    wr(4'd7, 0);
    chk_irq(1'b0, "R10 prio 2 equal top 2");
    wr(4'd7, 0);
    chk_irq(1'b1, "R10 stack empty");
    rd(4'd6, 32'h103, "R10 ack after unwinding");
    for (int k = 0; k < 8; k++) wr(4'd7, 0);
    pulse(10 - 7);
    chk_irq(1'b1, "R10 eight pops empty stack");
    rd(4'd6, 32'h103, "R10 ack after eight pops");
    wr(4'd7, 0);
    // R11 write protection
    wr(4'd9, {KEY, 8'h01}); rd(4'd9, 1, "R11 protect set");
    wr(4'd8, 32'h55); rd(4'd8, 32'hDEAD, "R11 spurious protected");
    wr(4'd0, 3); wr(4'd2, 32'h999); rd(4'd2, 32'h103, "R11 vector protected");
    wr(4'd1, 32'h27); rd(4'd1, 32'h22, "R11 mode protected");
    wr(4'd9, {24'h123456, 8'h00}); rd(4'd9, 1, "R11 wrong key ignored");
    wr(4'd9, {KEY, 8'h00}); rd(4'd9, 0, "R11 protect cleared");
    wr(4'd8, 32'h55); rd(4'd8, 32'h55, "R11 spurious writable");
    idle(6);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule